// File: doc/BRIEF.md
# Switchable-Ratio Third-Order Decimator

This block turns the single-bit output of an oversampling delta-sigma modulator into signed 16-bit words. It runs three integrators at the modulator sample rate and three differencers at the word rate, which together form a third-order moving-sum filter. The modulator bits arrive on a clock enable that a surrounding clock divider raises once every eight master clocks. One word leaves per decimation period, together with a one-cycle strobe.

The rate select chooses between two decimation ratios, 256 or 128, and may be changed while the block is running. The block shifts the filter result by a different amount for each ratio, so a given bit density yields the same code in both modes. A change of ratio restarts the filter from an empty state. A settled flag marks the words whose filter window holds only samples taken since the last restart.

Top module: `sinc3_decim`

## Requirements
- R1: A bit value of 1 counts as +1 and a value of 0 counts as -1. A steady stream of zeros gives the settled code -32768 (0x8000), and a steady stream of ones gives +32767 (0x7FFF).
- R2: With `rate_sel` at 0, one word is produced for every 256 enabled samples. With `rate_sel` at 1, one word is produced for every 128. When the enable pulses once every eight clocks, the strobes are 2048 or 1024 clocks apart.
- R3: A bit is taken only in a cycle where `smp_en` is high. The value of `bit_in` in any other cycle has no effect on the output, and no word appears while `smp_en` stays low.
- R4: Both ratios share one full scale. Once settled, a bit density of 3/4 gives +16384, a density of 1/4 gives -16384 and the alternating pattern 1,0 gives 0, in either mode.
- R5: A result above +32767 or below -32768 is clamped to that limit and never wraps.
- R6: While `rst` is high, the filter state is cleared. After the next clock, `word_data` reads 0 and `word_vld` and `word_settled` read 0.
- R7: A change of `rate_sel` clears the filter state, the word data and the settled flag at the next clock, even when it falls in the same cycle as a word boundary. After such a change or after a reset, the first three words carry `word_settled` = 0 and every later word carries 1.
- R8: `word_vld` is high for exactly one cycle per word. `word_data` stays unchanged between strobes unless a clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample enable, once every eight master clocks |
| bit_in | input | 1 | Modulator bit stream |
| rate_sel | input | 1 | 0: ratio 256, 1: ratio 128 |
| word_data | output | 16 | Signed output word, two's complement |
| word_vld | output | 1 | One-cycle strobe for a new word |
| word_settled | output | 1 | High when the filter window has refilled since the last restart |

## Verification
Two events can land on the same clock edge: a rate change and the sample that closes a decimation period. The bench counts clocks from an observed strobe so that the flip of `rate_sel` is captured on the same edge as the closing sample. It then expects `word_data` to drop to 0 and no strobe to follow. The bench also expects a full refill before `word_settled` rises again and a correct code from the new ratio. A reset placed in the middle of a period is judged the same way.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [ACC_W-1:0] acc_out
);
  logic [ACC_W-1:0] step_val;
  assign step_val = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic [ACC_W-1:0] q;
    logic [ACC_W-1:0] feed;
    if (k == 0) begin : g_first
      assign feed = step_val;
    end else begin : g_next
      assign feed = g_stage[k-1].q;
    end
    always_ff @(posedge clk) begin
      if (clr) q <= '0;
      else if (en) q <= q + feed;
    end
  end

  assign acc_out = g_stage[ORDER-1].q;

  // R6 / R7: a clear empties the last integrator
  p_clr_zero_r6: assert property (@(posedge clk) clr |=> acc_out == '0);
  // R3: no sample enable, no change of state
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (clr)
    !en |=> $stable(acc_out));
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 26
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             fire,
  input  logic [ACC_W-1:0] din,
  output logic [ACC_W-1:0] res,
  output logic             res_vld
);
  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    logic [ACC_W-1:0] dly;
    logic [ACC_W-1:0] src;
    logic [ACC_W-1:0] dif;
    if (k == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = g_stage[k-1].dif;
    end
    assign dif = src - dly;
    always_ff @(posedge clk) begin
      if (clr) dly <= '0;
      else if (fire) dly <= src;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= fire;
      if (fire) res <= g_stage[ORDER-1].dif;
    end
  end

  // R8: a result strobe never lasts two cycles
  p_res_pulse_r8: assert property (@(posedge clk) disable iff (clr)
    res_vld |=> !res_vld);
endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
  parameter int ACC_W   = 26,
  parameter int OUT_W   = 16,
  parameter int SH_SLOW = 9,
  parameter int SH_FAST = 6
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             in_vld,
  input  logic             fast,
  input  logic [ACC_W-1:0] din,
  output logic [OUT_W-1:0] word,
  output logic             word_vld
);
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM - ACC_W'(1);

  logic signed [ACC_W-1:0] shifted;
  logic [OUT_W-1:0]        clipped;

  always_comb begin
    shifted = fast ? ($signed(din) >>> SH_FAST) : ($signed(din) >>> SH_SLOW);
    if (shifted > POS_LIM)      clipped = {1'b0, {(OUT_W-1){1'b1}}};
    else if (shifted < NEG_LIM) clipped = {1'b1, {(OUT_W-1){1'b0}}};
    else                        clipped = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= in_vld;
      if (in_vld) word <= clipped;
    end
  end

  // R8: one-cycle strobe, data held while no new result arrives
  p_word_pulse_r8: assert property (@(posedge clk) disable iff (clr)
    word_vld |=> !word_vld);
  p_word_hold_r8: assert property (@(posedge clk) disable iff (clr)
    !in_vld |=> $stable(word));
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int OUT_W     = 16,
  parameter int LOG2_SLOW = 8,
  parameter int LOG2_FAST = 7,
  parameter int ORDER     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic             bit_in,
  input  logic             rate_sel,
  output logic [OUT_W-1:0] word_data,
  output logic             word_vld,
  output logic             word_settled
);
  import sinc3_pkg::*;

  localparam int ACC_W   = ORDER * LOG2_SLOW + 2;
  localparam int CNT_W   = LOG2_SLOW;
  localparam int SH_SLOW = ORDER * LOG2_SLOW - (OUT_W - 1);
  localparam int SH_FAST = ORDER * LOG2_FAST - (OUT_W - 1);
  localparam int WC_W    = $clog2(ORDER + 1);
  localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'((1 << LOG2_SLOW) - 1);
  localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'((1 << LOG2_FAST) - 1);

  rate_e            rate_q;
  logic             chg;
  logic             clr;
  logic [CNT_W-1:0] cnt;
  logic             at_last;
  logic             fire;
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] comb_out;
  logic             comb_vld;
  logic [WC_W-1:0]  wc;
  logic             settled_q;

  assign chg     = (rate_e'(rate_sel) != rate_q);
  assign clr     = rst | chg;
  assign at_last = (rate_q == RATE_FAST) ? (cnt == LAST_FAST) : (cnt == LAST_SLOW);
  assign fire    = smp_en & at_last & ~clr;

  always_ff @(posedge clk) begin
    if (rst) rate_q <= RATE_SLOW;
    else     rate_q <= rate_e'(rate_sel);
  end

  always_ff @(posedge clk) begin
    if (clr) cnt <= '0;
    else if (smp_en) cnt <= at_last ? '0 : cnt + 1'b1;
  end

  sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .clr(clr), .en(smp_en), .bit_in(bit_in), .acc_out(integ_out)
  );

  sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .clr(clr), .fire(fire), .din(integ_out),
    .res(comb_out), .res_vld(comb_vld)
  );

  sinc3_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_SLOW(SH_SLOW), .SH_FAST(SH_FAST)) u_scale (
    .clk(clk), .clr(clr), .in_vld(comb_vld), .fast(rate_q == RATE_FAST),
    .din(comb_out), .word(word_data), .word_vld(word_vld)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      wc        <= '0;
      settled_q <= 1'b0;
    end else if (comb_vld) begin
      settled_q <= (wc == WC_W'(ORDER));
      if (wc != WC_W'(ORDER)) wc <= wc + 1'b1;
    end
  end

  assign word_settled = settled_q;

  // R7: a rate change empties the period counter and the output stage
  p_rate_clear_r7: assert property (@(posedge clk) disable iff (rst)
    chg |=> (cnt == '0 && !word_vld && !word_settled));
  // R3: every word traces back to an enabled sample two clocks earlier
  p_vld_after_en_r3: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(smp_en, 2));
  // R7: the settled flag can only rise together with a word
  p_settle_word_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(word_settled) |-> word_vld);
  // R6: reset leaves quiet outputs
  p_reset_quiet_r6: assert property (@(posedge clk)
    rst |=> (!word_vld && word_data == '0 && !word_settled));
endmodule

// File: tb/test_sinc3_decim.sv
module test_sinc3_decim;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_en = 1'b0;
  logic        bit_in = 1'b0;
  logic        rate_sel = 1'b0;
  logic [15:0] word_data;
  logic        word_vld;
  logic        word_settled;

  always #5 clk = ~clk;

  sinc3_decim i_sinc3_decim (
    .clk(clk), .rst(rst), .smp_en(smp_en), .bit_in(bit_in), .rate_sel(rate_sel),
    .word_data(word_data), .word_vld(word_vld), .word_settled(word_settled)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0, ph = 0, sidx = 0, plen = 1;
  logic [7:0] pat = 8'h01;
  logic noise = 1'b0;
  logic collecting = 1'b0, prev_vld = 1'b0, hold_bad = 1'b0, done = 1'b0;
  logic [15:0] held;
  int wcount;
  int w_data [16];
  int w_set  [16];
  int w_cyc  [16];

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (collecting) begin
      if (word_vld) begin
        if (prev_vld) hold_bad = 1'b1;
        if (wcount < 16) begin
          w_data[wcount] = int'($signed(word_data));
          w_set[wcount]  = int'(word_settled);
          w_cyc[wcount]  = cyc;
        end
        wcount++;
        held = word_data;
      end else if (word_data !== held) hold_bad = 1'b1;
    end
    prev_vld = word_vld;
    ph = (ph + 1) % 8;
    smp_en = (ph == 0);
    if (smp_en) begin
      bit_in = pat[sidx % plen];
      sidx++;
    end else begin
      bit_in = noise ? ~pat[sidx % plen] : 1'b0;
    end
  endtask

  task automatic do_reset(input logic sel);
    rst = 1'b1; smp_en = 1'b0; rate_sel = sel;
    repeat (3) @(negedge clk);
    rst = 1'b0; ph = 0; sidx = 0; prev_vld = 1'b0;
  endtask

  task automatic run_collect(input int n);
    int guard = 0;
    collecting = 1'b1; wcount = 0; held = word_data; hold_bad = 1'b0;
    while (wcount < n && guard < n * 2048 + 4096) begin
      tick();
      guard++;
    end
    collecting = 1'b0;
    chk("R8 one-cycle strobe and held data", int'(hold_bad), 0);
    chk("R2 word count within window", wcount, n);
  endtask

  function automatic int expect_code(input logic [7:0] p, input int len);
    int ones = 0;
    int v;
    for (int i = 0; i < len; i++) ones += int'(p[i]);
    v = ((2 * ones - len) * 32768) / len;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic check_words(input string tag, input int n, input int dr, input int exp);
    for (int i = 0; i < n; i++) begin
      chk("R7 settled flag", w_set[i], (i >= 3) ? 1 : 0);
      if (i >= 3) chk(tag, w_data[i], exp);
      if (i >= 1) chk("R2 strobe spacing", w_cyc[i] - w_cyc[i-1], dr * 8);
    end
  endtask

  task automatic t_dc(input string tag, input logic sel, input logic [7:0] p, input int len,
                      input logic nz);
    do_reset(sel);
    pat = p; plen = len; noise = nz;
    run_collect(6);
    check_words(tag, 6, sel ? 128 : 256, expect_code(p, len));
    noise = 1'b0;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 data at reset", int'(word_data), 0);
    chk("R6 strobe at reset", int'(word_vld), 0);
    chk("R6 settled at reset", int'(word_settled), 0);
  endtask

  task automatic t_idle();
    int seen = 0;
    do_reset(1'b0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      smp_en = 1'b0; bit_in = i[0];
      if (word_vld) seen++;
    end
    chk("R3 no word without sample enable", seen, 0);
  endtask

  task automatic t_rate_switch();
    do_reset(1'b0);
    pat = 8'h01; plen = 1;
    run_collect(4);
    chk("R5 clamp before switch", w_data[3], 32767);
    repeat (2045) tick();
    rate_sel = 1'b1;
    pat = 8'h01; plen = 4;
    tick();
    tick();
    chk("R7 data cleared on switch at word boundary", int'(word_data), 0);
    chk("R7 no strobe after colliding switch", int'(word_vld), 0);
    chk("R7 settled cleared on switch", int'(word_settled), 0);
    tick();
    chk("R7 still no strobe", int'(word_vld), 0);
    run_collect(5);
    check_words("R4 code after switch to ratio 128", 5, 128, -16384);
  endtask

  task automatic t_mid_reset();
    do_reset(1'b0);
    pat = 8'h00; plen = 1;
    run_collect(2);
    repeat (700) tick();
    rst = 1'b1;
    tick();
    tick();
    chk("R6 data after mid-run reset", int'(word_data), 0);
    chk("R6 settled after mid-run reset", int'(word_settled), 0);
    rst = 1'b0;
    run_collect(5);
    check_words("R1 all-zeros after mid-run reset", 5, 256, -32768);
  endtask

  initial begin
    t_reset_state();
    t_dc("R1/R5 all-ones ratio 256 with off-enable noise R3", 1'b0, 8'h01, 1, 1'b1);
    t_dc("R1/R5 all-zeros ratio 256 with off-enable noise R3", 1'b0, 8'h00, 1, 1'b1);
    t_dc("R4 density 3/4 ratio 256", 1'b0, 8'h07, 4, 1'b0);
    t_dc("R4 alternating ratio 256", 1'b0, 8'h01, 2, 1'b0);
    t_dc("R4 density 3/4 ratio 128", 1'b1, 8'h07, 4, 1'b0);
    t_dc("R4 density 1/4 ratio 128", 1'b1, 8'h01, 4, 1'b0);
    t_dc("R4 alternating ratio 128", 1'b1, 8'h01, 2, 1'b0);
    t_dc("R1/R5 all-ones ratio 128", 1'b1, 8'h01, 1, 1'b0);
    t_idle();
    t_rate_switch();
    t_mid_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R2 watchdog: cycles=%0d expected below %0d", cyc, 195000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule